// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the processor-side register set of a four-channel DMA controller in the classic PC style. A host reaches it through sixteen byte-wide I/O offsets, using a 4-bit offset, write data, registered read data and separate read and write strobes. Each channel keeps a 16-bit base and current address and a 16-bit base and current count. These 16-bit values pass through the 8-bit port one byte at a time, steered by one shared low/high byte pointer. Alongside them sit a command register, a request register, a per-channel mode field, a four-bit channel mask, a status register and a temporary register.

A separate transfer engine reads all of these through the output ports. It reports back through update inputs: new current address and count for one channel, set and clear pulses for status bits, mask-set pulses on completion, and a temporary-register load. Several offsets are actions rather than storage: clear the byte pointer, master reset, and clear the mask.

Two small state machines sequence the block. The byte pointer has states PTR_LO and PTR_HI. An address or count access moves PTR_LO to PTR_HI and PTR_HI back to PTR_LO. A pointer clear or a master reset forces either state to PTR_LO. The status-clear sequencer has states SC_IDLE and SC_PEND. A status read moves SC_IDLE to SC_PEND. While in SC_PEND, a further status read keeps it in SC_PEND and any other cycle returns it to SC_IDLE. In SC_PEND, terminal-count bits are cleared at the next edge.

Top module: `dma_rf_top`

## Requirements
- R1: After hardware reset, every channel's base and current address and count are 0 and every mode field is 0. Command, request, status and temporary registers are 0, the mask is 4'b1111, the byte pointer selects the low byte, and io_rdata is 0.
- R2: A write to offset 2n loads channel n's address register, and a write to offset 2n+1 loads its count register, for n in 0..3. The byte written is the low byte [7:0] when the pointer is low and the high byte [15:8] when it is high. The base and current copies both take the byte, and the pointer then flips.
- R3: A read of offset 2n or 2n+1 returns the selected byte of channel n's current address or current count on io_rdata at the clock edge that samples io_rd, and the pointer flips. Every read response in the block arrives on that same edge.
- R4: A write of any value to offset 0xC returns the byte pointer to low.
- R5: A write to offset 0x8 loads the command register and a write to offset 0x9 loads the request register. A write to offset 0xB stores data bits [7:2] into the 6-bit mode field of the channel numbered by data bits [1:0]. mode_o holds channel n's field at bits [6n+5:6n].
- R6: A write to offset 0xA with data bit 2 set masks the channel numbered by data bits [1:0]; with bit 2 clear, it unmasks that channel. Other mask bits keep their values.
- R7: A write to offset 0xF loads all four mask bits from data bits [3:0]. A read of 0xF returns {4'b0000, mask}.
- R8: A write of any value to offset 0xE clears all four mask bits.
- R9: A write to offset 0xD clears command, request, status, temporary register and the byte pointer, and sets all four mask bits. Base, current and mode registers are unchanged. A read of 0xD returns the temporary register.
- R10: Reads of offsets 0x9, 0xA, 0xB, 0xC and 0xE return 0xFF and change no state.
- R11: A read of offset 0x8 returns the status byte. Bits [3:0] are terminal-count flags and bits [7:4] are request flags. One edge after the read edge, bits [3:0] are cleared, except bits that the engine sets in that same cycle. Bits [7:4] are unaffected by the read.
- R12: While eng_we is high, the current address and count of channel eng_ch take eng_addr and eng_cnt, and the base copies are untouched. Each cycle, status becomes (status & ~eng_sts_clr) | eng_sts_set. eng_mask_set ORs into the mask, and eng_tmp_we loads the temporary register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 4 | I/O offset |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe (wins over io_rd) |
| io_rdata | output | 8 | Registered read data |
| eng_we | input | 1 | Engine current-register update |
| eng_ch | input | 2 | Channel of the engine update |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| eng_sts_set | input | 8 | Status bits to set |
| eng_sts_clr | input | 8 | Status bits to clear |
| eng_mask_set | input | 4 | Mask bits to set |
| eng_tmp_we | input | 1 | Temporary register load |
| eng_tmp_d | input | 8 | Temporary register data |
| cmd_o | output | 8 | Command register |
| req_o | output | 8 | Request register |
| mask_o | output | 4 | Channel mask |
| status_o | output | 8 | Status register |
| mode_o | output | 24 | Mode fields, 6 bits per channel |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| cur_addr_o | output | 64 | Current addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |
| cur_cnt_o | output | 64 | Current counts, 16 bits per channel |

## Verification
Every register write and every engine update is visible on the outputs after the single edge that samples it. Read data appears on io_rdata at that same edge, so the bench drives on the falling edge and checks at the next falling edge. Each host or engine operation is followed by one idle cycle. That idle cycle gives the deferred terminal-count clear of a status read its second edge before the next comparison. A directed case places an engine set in exactly that second cycle to show that the set survives the clear.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int NCH   = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int REGW  = 16;
    localparam int BYTEW = 8;
    localparam int MODEW = BYTEW - CHW;

    localparam logic [3:0] OFS_STATUS  = 4'h8;
    localparam logic [3:0] OFS_REQ     = 4'h9;
    localparam logic [3:0] OFS_SMASK   = 4'hA;
    localparam logic [3:0] OFS_MODE    = 4'hB;
    localparam logic [3:0] OFS_PTRCLR  = 4'hC;
    localparam logic [3:0] OFS_MRST    = 4'hD;
    localparam logic [3:0] OFS_MASKCLR = 4'hE;
    localparam logic [3:0] OFS_AMASK   = 4'hF;

    typedef enum logic {PTR_LO, PTR_HI} ptr_state_t;
    typedef enum logic {SC_IDLE, SC_PEND} stsclr_state_t;
endpackage

// File: rtl/dma_rf_seq.sv
module dma_rf_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic ptr_clr,
    input  logic sts_rd,
    output logic hi_sel,
    output logic tc_clr
);
    import dma_rf_pkg::*;

    ptr_state_t    ptr_q, ptr_d;
    stsclr_state_t sc_q, sc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= PTR_LO;
            sc_q  <= SC_IDLE;
        end else begin
            ptr_q <= ptr_d;
            sc_q  <= sc_d;
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        unique case (ptr_q)
            PTR_LO: if (!ptr_clr && step) ptr_d = PTR_HI;
            PTR_HI: if (ptr_clr || step)  ptr_d = PTR_LO;
        endcase
        sc_d = sc_q;
        unique case (sc_q)
            SC_IDLE: if (sts_rd)  sc_d = SC_PEND;
            SC_PEND: if (!sts_rd) sc_d = SC_IDLE;
        endcase
    end

    always_comb begin
        hi_sel = (ptr_q == PTR_HI);
        tc_clr = (sc_q == SC_PEND);
    end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan #(
    parameter int REGW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_sel,
    input  logic [REGW/2-1:0] wbyte,
    input  logic              eng_we,
    input  logic [REGW-1:0]   eng_addr,
    input  logic [REGW-1:0]   eng_cnt,
    output logic [REGW-1:0]   base_addr,
    output logic [REGW-1:0]   cur_addr,
    output logic [REGW-1:0]   base_cnt,
    output logic [REGW-1:0]   cur_cnt
);
    localparam int HB = REGW / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (addr_we) begin
            if (hi_sel) begin
                base_addr[REGW-1:HB] <= wbyte;
                cur_addr[REGW-1:HB]  <= wbyte;
            end else begin
                base_addr[HB-1:0] <= wbyte;
                cur_addr[HB-1:0]  <= wbyte;
            end
        end else if (eng_we) begin
            cur_addr <= eng_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (cnt_we) begin
            if (hi_sel) begin
                base_cnt[REGW-1:HB] <= wbyte;
                cur_cnt[REGW-1:HB]  <= wbyte;
            end else begin
                base_cnt[HB-1:0] <= wbyte;
                cur_cnt[HB-1:0]  <= wbyte;
            end
        end else if (eng_we) begin
            cur_cnt <= eng_cnt;
        end
    end
endmodule

// File: rtl/dma_rf_ctl.sv
module dma_rf_ctl
    import dma_rf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTEW-1:0]     wdata,
    input  logic                 cmd_we,
    input  logic                 req_we,
    input  logic                 smask_we,
    input  logic                 amask_we,
    input  logic                 maskclr_we,
    input  logic                 mode_we,
    input  logic                 mrst,
    input  logic                 tc_clr,
    input  logic [BYTEW-1:0]     eng_sts_set,
    input  logic [BYTEW-1:0]     eng_sts_clr,
    input  logic [NCH-1:0]       eng_mask_set,
    input  logic                 eng_tmp_we,
    input  logic [BYTEW-1:0]     eng_tmp_d,
    output logic [BYTEW-1:0]     cmd,
    output logic [BYTEW-1:0]     req,
    output logic [NCH-1:0]       mask,
    output logic [BYTEW-1:0]     status,
    output logic [BYTEW-1:0]     temp,
    output logic [NCH*MODEW-1:0] mode_flat
);
    logic [NCH-1:0]   mask_d;
    logic [BYTEW-1:0] status_d;
    logic [CHW-1:0]   wch;

    assign wch = wdata[CHW-1:0];

    always_comb begin
        mask_d = mask;
        if (mrst)            mask_d = '1;
        else if (amask_we)   mask_d = wdata[NCH-1:0];
        else if (maskclr_we) mask_d = '0;
        else if (smask_we)   mask_d[wch] = wdata[CHW];
        mask_d = mask_d | eng_mask_set;
    end

    always_comb begin
        status_d = status;
        if (tc_clr) status_d[NCH-1:0] = '0;
        status_d = (status_d & ~eng_sts_clr) | eng_sts_set;
        if (mrst) status_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd    <= '0;
            req    <= '0;
            mask   <= '1;
            status <= '0;
            temp   <= '0;
        end else begin
            mask   <= mask_d;
            status <= status_d;
            if (mrst) begin
                cmd  <= '0;
                req  <= '0;
                temp <= '0;
            end else begin
                if (cmd_we)     cmd  <= wdata;
                if (req_we)     req  <= wdata;
                if (eng_tmp_we) temp <= eng_tmp_d;
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_mode
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mode_flat[i*MODEW +: MODEW] <= '0;
            else if (mode_we && (wch == CHW'(i)))
                mode_flat[i*MODEW +: MODEW] <= wdata[BYTEW-1:CHW];
        end
    end
endmodule

// File: rtl/dma_rf_top.sv
module dma_rf_top
    import dma_rf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           io_addr,
    input  logic [BYTEW-1:0]     io_wdata,
    input  logic                 io_rd,
    input  logic                 io_wr,
    output logic [BYTEW-1:0]     io_rdata,
    input  logic                 eng_we,
    input  logic [CHW-1:0]       eng_ch,
    input  logic [REGW-1:0]      eng_addr,
    input  logic [REGW-1:0]      eng_cnt,
    input  logic [BYTEW-1:0]     eng_sts_set,
    input  logic [BYTEW-1:0]     eng_sts_clr,
    input  logic [NCH-1:0]       eng_mask_set,
    input  logic                 eng_tmp_we,
    input  logic [BYTEW-1:0]     eng_tmp_d,
    output logic [BYTEW-1:0]     cmd_o,
    output logic [BYTEW-1:0]     req_o,
    output logic [NCH-1:0]       mask_o,
    output logic [BYTEW-1:0]     status_o,
    output logic [NCH*MODEW-1:0] mode_o,
    output logic [NCH*REGW-1:0]  base_addr_o,
    output logic [NCH*REGW-1:0]  cur_addr_o,
    output logic [NCH*REGW-1:0]  base_cnt_o,
    output logic [NCH*REGW-1:0]  cur_cnt_o
);
    logic           wr_acc, rd_acc, is_chan, step, ptr_clr, sts_rd, mrst;
    logic           ptr_hi, tc_clr;
    logic [CHW-1:0] ch_sel;
    logic [BYTEW-1:0] temp_q, rd_next;
    logic [REGW-1:0]  cur_addr_a [NCH];
    logic [REGW-1:0]  cur_cnt_a  [NCH];
    logic [REGW-1:0]  rd_word;

    assign wr_acc  = io_wr;
    assign rd_acc  = io_rd & ~io_wr;
    assign is_chan = ~io_addr[3];
    assign ch_sel  = io_addr[CHW:1];
    assign step    = (wr_acc | rd_acc) & is_chan;
    assign mrst    = wr_acc & (io_addr == OFS_MRST);
    assign ptr_clr = (wr_acc & (io_addr == OFS_PTRCLR)) | mrst;
    assign sts_rd  = rd_acc & (io_addr == OFS_STATUS);

    dma_rf_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .ptr_clr (ptr_clr),
        .sts_rd  (sts_rd),
        .hi_sel  (ptr_hi),
        .tc_clr  (tc_clr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic sel_i;
        assign sel_i = wr_acc & is_chan & (ch_sel == CHW'(i));
        dma_rf_chan #(.REGW(REGW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_we   (sel_i & ~io_addr[0]),
            .cnt_we    (sel_i &  io_addr[0]),
            .hi_sel    (ptr_hi),
            .wbyte     (io_wdata),
            .eng_we    (eng_we & (eng_ch == CHW'(i))),
            .eng_addr  (eng_addr),
            .eng_cnt   (eng_cnt),
            .base_addr (base_addr_o[i*REGW +: REGW]),
            .cur_addr  (cur_addr_o[i*REGW +: REGW]),
            .base_cnt  (base_cnt_o[i*REGW +: REGW]),
            .cur_cnt   (cur_cnt_o[i*REGW +: REGW])
        );
        assign cur_addr_a[i] = cur_addr_o[i*REGW +: REGW];
        assign cur_cnt_a[i]  = cur_cnt_o[i*REGW +: REGW];
    end

    dma_rf_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdata        (io_wdata),
        .cmd_we       (wr_acc & (io_addr == OFS_STATUS)),
        .req_we       (wr_acc & (io_addr == OFS_REQ)),
        .smask_we     (wr_acc & (io_addr == OFS_SMASK)),
        .amask_we     (wr_acc & (io_addr == OFS_AMASK)),
        .maskclr_we   (wr_acc & (io_addr == OFS_MASKCLR)),
        .mode_we      (wr_acc & (io_addr == OFS_MODE)),
        .mrst         (mrst),
        .tc_clr       (tc_clr),
        .eng_sts_set  (eng_sts_set),
        .eng_sts_clr  (eng_sts_clr),
        .eng_mask_set (eng_mask_set),
        .eng_tmp_we   (eng_tmp_we),
        .eng_tmp_d    (eng_tmp_d),
        .cmd          (cmd_o),
        .req          (req_o),
        .mask         (mask_o),
        .status       (status_o),
        .temp         (temp_q),
        .mode_flat    (mode_o)
    );

    always_comb begin
        rd_word = io_addr[0] ? cur_cnt_a[ch_sel] : cur_addr_a[ch_sel];
        rd_next = 8'hFF;
        if (is_chan) begin
            rd_next = ptr_hi ? rd_word[REGW-1:REGW/2] : rd_word[REGW/2-1:0];
        end else begin
            case (io_addr)
                OFS_STATUS: rd_next = status_o;
                OFS_MRST:   rd_next = temp_q;
                OFS_AMASK:  rd_next = {{(BYTEW-NCH){1'b0}}, mask_o};
                default:    rd_next = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      io_rdata <= '0;
        else if (rd_acc) io_rdata <= rd_next;
    end
endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk
    import dma_rf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           io_addr,
    input logic [BYTEW-1:0]     io_wdata,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [BYTEW-1:0]     io_rdata,
    input logic [BYTEW-1:0]     eng_sts_set,
    input logic [NCH-1:0]       eng_mask_set,
    input logic [NCH-1:0]       mask_o,
    input logic [BYTEW-1:0]     status_o,
    input logic [NCH*MODEW-1:0] mode_o,
    input logic                 ptr_hi
);
    AST_MRST_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MRST) |=> (mask_o == '1)); // R9

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MASKCLR && eng_mask_set == '0) |=> (mask_o == '0)); // R8

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_PTRCLR) |=> !ptr_hi); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !io_addr[3]) |=> (ptr_hi != $past(ptr_hi))); // R2

    AST_WO_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == OFS_REQ) |=> (io_rdata == 8'hFF)); // R10

    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(io_rd && !io_wr && io_addr == OFS_STATUS) && !(io_wr && io_addr == OFS_MRST)
         && eng_sts_set[NCH-1:0] == '0) |=> (status_o[NCH-1:0] == '0)); // R11

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MODE)
        |=> (mode_o[$past(io_wdata[CHW-1:0])*MODEW +: MODEW] == $past(io_wdata[BYTEW-1:CHW]))); // R5
endmodule

bind dma_rf_top dma_rf_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .io_rdata     (io_rdata),
    .eng_sts_set  (eng_sts_set),
    .eng_mask_set (eng_mask_set),
    .mask_o       (mask_o),
    .status_o     (status_o),
    .mode_o       (mode_o),
    .ptr_hi       (ptr_hi)
);

// File: tb/dma_rf_top_tb_top.sv
module dma_rf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic        eng_we = 1'b0;
    logic [1:0]  eng_ch = '0;
    logic [15:0] eng_addr = '0, eng_cnt = '0;
    logic [7:0]  eng_sts_set = '0, eng_sts_clr = '0;
    logic [3:0]  eng_mask_set = '0;
    logic        eng_tmp_we = 1'b0;
    logic [7:0]  eng_tmp_d = '0;
    logic [7:0]  cmd_o, req_o, status_o;
    logic [3:0]  mask_o;
    logic [23:0] mode_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
    logic [5:0]  m_mode [4];
    logic [7:0]  m_cmd, m_req, m_sts, m_tmp;
    logic [3:0]  m_mask;
    bit          m_hi;

    always #4 clk = ~clk;

    dma_rf_top dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
        end
        m_cmd = 0; m_req = 0; m_sts = 0; m_tmp = 0; m_mask = 4'hF; m_hi = 0;
    endtask

    task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
        int ch;
        ch = int'(a[2:1]);
        if (!a[3]) begin
            if (a[0]) begin
                if (m_hi) begin m_bc[ch][15:8] = d; m_cc[ch][15:8] = d; end
                else      begin m_bc[ch][7:0]  = d; m_cc[ch][7:0]  = d; end
            end else begin
                if (m_hi) begin m_ba[ch][15:8] = d; m_ca[ch][15:8] = d; end
                else      begin m_ba[ch][7:0]  = d; m_ca[ch][7:0]  = d; end
            end
            m_hi = !m_hi;
        end else begin
            case (a)
                4'h8: m_cmd = d;
                4'h9: m_req = d;
                4'hA: m_mask[d[1:0]] = d[2];
                4'hB: m_mode[d[1:0]] = d[7:2];
                4'hC: m_hi = 0;
                4'hD: begin m_cmd = 0; m_req = 0; m_sts = 0; m_tmp = 0; m_hi = 0; m_mask = 4'hF; end
                4'hE: m_mask = 0;
                default: m_mask = d[3:0];
            endcase
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [15:0] w;
        if (!a[3]) begin
            w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
            return m_hi ? w[15:8] : w[7:0];
        end
        case (a)
            4'h8:    return m_sts;
            4'hD:    return m_tmp;
            4'hF:    return {4'h0, m_mask};
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check_all(input string tag);
        chk({"R5 cmd ", tag}, cmd_o, m_cmd);
        chk({"R5 req ", tag}, req_o, m_req);
        chk({"R6 mask ", tag}, mask_o, m_mask);
        chk({"R12 status ", tag}, status_o, m_sts);
        for (int i = 0; i < 4; i++) begin
            chk({"R2 base addr ", tag}, base_addr_o[i*16 +: 16], m_ba[i]);
            chk({"R2 cur addr ", tag},  cur_addr_o[i*16 +: 16],  m_ca[i]);
            chk({"R2 base cnt ", tag},  base_cnt_o[i*16 +: 16],  m_bc[i]);
            chk({"R12 cur cnt ", tag},  cur_cnt_o[i*16 +: 16],   m_cc[i]);
            chk({"R5 mode ", tag},      mode_o[i*6 +: 6],        m_mode[i]);
        end
    endtask

    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(posedge clk); @(negedge clk);
        io_wr = 0;
        model_wr(a, d);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic cpu_rd(input logic [3:0] a, input string req);
        logic [7:0] e;
        e = exp_rd(a);
        io_addr = a; io_rd = 1;
        @(posedge clk); @(negedge clk);
        io_rd = 0;
        chk(req, io_rdata, e);
        if (!a[3]) m_hi = !m_hi;
        if (a == 4'h8) m_sts[3:0] = 0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic eng_op(input bit we, input logic [1:0] ch, input logic [15:0] ad,
                          input logic [15:0] cn, input logic [7:0] ss, input logic [7:0] sc,
                          input logic [3:0] ms, input bit tw, input logic [7:0] td);
        eng_we = we; eng_ch = ch; eng_addr = ad; eng_cnt = cn;
        eng_sts_set = ss; eng_sts_clr = sc; eng_mask_set = ms; eng_tmp_we = tw; eng_tmp_d = td;
        @(posedge clk); @(negedge clk);
        eng_we = 0; eng_sts_set = 0; eng_sts_clr = 0; eng_mask_set = 0; eng_tmp_we = 0;
        if (we) begin m_ca[ch] = ad; m_cc[ch] = cn; end
        m_sts = (m_sts & ~sc) | ss;
        m_mask = m_mask | ms;
        if (tw) m_tmp = td;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", io_rdata, 8'h00);
        check_all("R1");
        cpu_rd(4'h0, "R1 pointer low after reset");

        // R2/R3 16-bit write and readback, channel 2 address
        cpu_wr(4'hC, 8'h00);
        cpu_wr(4'h4, 8'h34);
        cpu_wr(4'h4, 8'h12);
        check_all("R2 word");
        cpu_rd(4'h4, "R3 low byte");
        cpu_rd(4'h4, "R3 high byte");

        // R4 pointer clear between bytes
        cpu_wr(4'h7, 8'hAA);
        cpu_wr(4'hC, 8'h5A);
        cpu_wr(4'h7, 8'hBB);
        check_all("R4");

        // R6/R7/R8 mask handling
        cpu_wr(4'hF, 8'hF5);
        cpu_rd(4'hF, "R7 mask readback");
        cpu_wr(4'hA, 8'h01);
        cpu_wr(4'hA, 8'h06);
        check_all("R6");
        cpu_wr(4'hE, 8'h00);
        check_all("R8");

        // R5 mode of channel 3
        cpu_wr(4'hB, 8'hA7);
        check_all("R5");

        // R10 write-only offsets read 0xFF
        cpu_rd(4'h9, "R10 off9");
        cpu_rd(4'hA, "R10 offA");
        cpu_rd(4'hB, "R10 offB");
        cpu_rd(4'hC, "R10 offC");
        cpu_rd(4'hE, "R10 offE");
        check_all("R10");

        // R9 master reset
        eng_op(0, 0, 0, 0, 8'h00, 8'h00, 4'h0, 1, 8'h3C);
        cpu_rd(4'hD, "R9 temp readback");
        cpu_wr(4'h8, 8'h44);
        cpu_wr(4'h1, 8'h99);
        cpu_wr(4'hD, 8'h00);
        check_all("R9");
        cpu_rd(4'hD, "R9 temp cleared");

        // R11 status read clears TC bits, same-cycle engine set survives
        eng_op(0, 0, 0, 0, 8'h35, 8'h00, 4'h0, 0, 0);
        io_addr = 4'h8; io_rd = 1;
        @(posedge clk); @(negedge clk);
        io_rd = 0; eng_sts_set = 8'h02;
        chk("R11 status read value", io_rdata, 8'h35);
        @(posedge clk); @(negedge clk);
        eng_sts_set = 0;
        m_sts = 8'h32;
        chk("R11 clear with engine set", status_o, 8'h32);
        @(posedge clk); @(negedge clk);
        cpu_rd(4'h8, "R11 second read");
        chk("R11 tc cleared", status_o, 8'h30);

        // R12 engine update leaves base copies
        eng_op(1, 2'd1, 16'hBEEF, 16'h0102, 8'h00, 8'h10, 4'h2, 0, 0);
        check_all("R12");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 5)
                cpu_wr(4'($urandom_range(0, 15)), 8'($urandom));
            else if (k < 8)
                cpu_rd(4'($urandom_range(0, 15)), "R3 random read");
            else
                eng_op(1'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
                       8'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 8'($urandom));
            check_all("random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule